// File: doc/BRIEF.md
# Serial SAR Converter Conversion Sequencer

This block sits on the host side of an external 12-bit successive-approximation converter that has a three-wire serial link: a conversion-start strobe, a serial clock and a serial data line from the converter. When the host pulses a start request, the sequencer raises the strobe. The rising edge powers the converter up and starts tracking. The strobe stays high for a power-up interval plus an acquisition interval, and its falling edge freezes the sample and starts the conversion. The sequencer then waits out the conversion time. It clocks in the result MSB first, sampling the data line on each rising serial clock edge, and presents the word with a one-cycle valid pulse.

The converter has no channel-select pin. If a readout is cut short before all bits are clocked out, the converter uses its second input on the next strobe. Otherwise it uses the first. The sequencer models this and reports the channel the converter will use next and the channel each result came from. When the host asks for the second input, the sequencer first runs a priming pass. The priming pass is a full strobe and conversion wait with no serial clocks at all, so the real conversion that follows lands on the second input.

The controller is a single state machine. The states are IDLE, STROBE, CONVERT, CLK_LO, CLK_HI and DONE. The transitions are:
- IDLE to STROBE on a start request.
- STROBE to CONVERT when the strobe interval expires.
- CONVERT to CLK_LO when the conversion wait expires on a normal pass.
- CONVERT to STROBE when the conversion wait expires on a priming pass (readout aborted).
- CLK_LO to CLK_HI at the end of a low half-period, where the data bit is captured.
- CLK_HI to CLK_LO at the end of a high half-period while bits remain.
- CLK_HI to DONE after the last bit.
- DONE to IDLE unconditionally.

All intervals are parameters counted in system clock cycles.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is held and just after it, strobe_o, sclk_o, busy_o and valid_o are 0, next_ch_o is 0 and result_o is 0.
- R2: A start_i sampled high in IDLE raises strobe_o on the next clock edge. strobe_o then stays high for exactly PWRUP_CYC+TRACK_CYC cycles per pass.
- R3: After strobe_o falls, sclk_o stays low for CONV_CYC cycles of conversion wait plus one low half-period of HALF_CYC cycles. The first sclk_o high cycle therefore comes CONV_CYC+HALF_CYC+1 cycles after the last strobe_o high cycle.
- R4: A readout gives exactly NBITS sclk_o pulses. Each pulse is high for HALF_CYC cycles and separated by HALF_CYC low cycles. sclk_o idles low and is never high while strobe_o is high.
- R5: sdata_i is sampled at each rising sclk_o edge. The first sample is bit NBITS-1 (MSB) of result_o and the last is bit 0.
- R6: valid_o is a single-cycle pulse in the cycle after the last sclk_o high phase, and it carries the new result_o. result_o holds its value in every cycle without valid_o.
- R7: busy_o is high from the cycle after the accepted start through the valid_o cycle, and low in the cycle after it. That is passes*(PWRUP_CYC+TRACK_CYC+CONV_CYC)+2*NBITS*HALF_CYC+1 cycles.
- R8: start_i pulses while busy_o is high are ignored. The ongoing conversion is unchanged and no new strobe follows it.
- R9: ch2_req_i=1 together with an accepted start (while next_ch_o is 0) runs a priming pass: one strobe, one conversion wait and zero sclk_o pulses. A second strobe follows, and next_ch_o reads 1 from that second rising strobe edge. The result then comes from the second input, and result_ch_o is 1.
- R10: A completed readout sets next_ch_o to 0 by the valid_o cycle. result_ch_o gives the channel of the presented result (0 = first input, 1 = second input).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled in IDLE only |
| ch2_req_i | input | 1 | Request the second input for this conversion, sampled with start_i |
| sdata_i | input | 1 | Serial data from the converter |
| strobe_o | output | 1 | Conversion-start strobe to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles low |
| busy_o | output | 1 | Sequence in progress |
| valid_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | NBITS | Last completed conversion result |
| result_ch_o | output | 1 | Input channel of result_o |
| next_ch_o | output | 1 | Input the converter will use on its next strobe |

## Verification
The bench builds the sequencer with PWRUP_CYC=2, TRACK_CYC=3, CONV_CYC=7 and HALF_CYC=1. With these values a whole conversion takes about forty cycles. That makes it possible to sweep 1024 codes and step through every one of the twelve bit positions with walking-one and walking-zero words. A bench model of the converter loads its word on the falling strobe edge and shifts on the falling serial clock edge. It also switches to its second input after any short readout, so channel tracking is checked against an independent behaviour. Priming passes and start requests landing mid-conversion are mixed into the sweep at fixed intervals.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_STROBE  = 3'd1,
        ST_CONVERT = 3'd2,
        ST_CLK_LO  = 3'd3,
        ST_CLK_HI  = 3'd4,
        ST_DONE    = 3'd5
    } seq_state_e;

endpackage

// File: rtl/sar_seq_timer.sv
// Interval counter: restarts on each state change, flags the final cycle of
// the current interval and then holds.
module sar_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          last
);

    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == (limit - CW'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!last) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/sar_seq_shift.sv
// MSB-first capture register for the serial result.
module sar_seq_shift #(
    parameter int NBITS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [NBITS-1:0] word
);

    logic [NBITS-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (shift_en) begin
            word_q <= {word_q[NBITS-2:0], din};
        end
    end

    assign word = word_q;

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int NBITS     = 12,
    parameter int PWRUP_CYC = 50,
    parameter int TRACK_CYC = 70,
    parameter int CONV_CYC  = 185,
    parameter int HALF_CYC  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ch2_req_i,
    input  logic             sdata_i,
    output logic             strobe_o,
    output logic             sclk_o,
    output logic             busy_o,
    output logic             valid_o,
    output logic [NBITS-1:0] result_o,
    output logic             result_ch_o,
    output logic             next_ch_o
);

    localparam int STROBE_CYC = PWRUP_CYC + TRACK_CYC;
    localparam int MAX_A      = (STROBE_CYC > CONV_CYC) ? STROBE_CYC : CONV_CYC;
    localparam int MAX_CYC    = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
    localparam int CW         = $clog2(MAX_CYC + 1);
    localparam int BW         = (NBITS > 2) ? $clog2(NBITS) : 1;

    seq_state_e       state_q, state_d;
    logic [CW-1:0]    limit;
    logic             tlast;
    logic             restart;
    logic [BW-1:0]    bit_q;
    logic             prime_q;
    logic             next_ch_q;
    logic             conv_ch_q;
    logic             res_ch_q;
    logic [NBITS-1:0] result_q;
    logic [NBITS-1:0] cap_word;
    logic             cap_en;
    logic             last_bit;

    assign restart  = (state_d != state_q);
    assign last_bit = (bit_q == BW'(NBITS - 1));
    assign cap_en   = (state_q == ST_CLK_LO) && tlast;

    sar_seq_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .last    (tlast)
    );

    sar_seq_shift #(.NBITS(NBITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cap_en),
        .din      (sdata_i),
        .word     (cap_word)
    );

    // interval length per state
    always_comb begin
        unique case (state_q)
            ST_STROBE:           limit = CW'(STROBE_CYC);
            ST_CONVERT:          limit = CW'(CONV_CYC);
            ST_CLK_LO, ST_CLK_HI: limit = CW'(HALF_CYC);
            default:             limit = CW'(1);
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_STROBE;
            ST_STROBE:  if (tlast)   state_d = ST_CONVERT;
            ST_CONVERT: if (tlast)   state_d = prime_q ? ST_STROBE : ST_CLK_LO;
            ST_CLK_LO:  if (tlast)   state_d = ST_CLK_HI;
            ST_CLK_HI:  if (tlast)   state_d = last_bit ? ST_DONE : ST_CLK_LO;
            ST_DONE:                 state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // sequence bookkeeping: bit index, priming flag, channel model, result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q     <= '0;
            prime_q   <= 1'b0;
            next_ch_q <= 1'b0;
            conv_ch_q <= 1'b0;
            res_ch_q  <= 1'b0;
            result_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start_i) begin
                prime_q <= ch2_req_i && !next_ch_q;
                bit_q   <= '0;
            end
            if (state_d == ST_STROBE && state_q != ST_STROBE) begin
                // a rising strobe after an aborted readout lands on input 2
                conv_ch_q <= (state_q == ST_CONVERT) ? 1'b1 : next_ch_q;
            end
            if (state_q == ST_CONVERT && tlast && prime_q) begin
                prime_q   <= 1'b0;
                next_ch_q <= 1'b1;
            end
            if (state_q == ST_CLK_HI && tlast) begin
                if (last_bit) begin
                    result_q  <= cap_word;
                    res_ch_q  <= conv_ch_q;
                    next_ch_q <= 1'b0;
                end else begin
                    bit_q <= bit_q + BW'(1);
                end
            end
        end
    end

    // Moore outputs
    always_comb begin
        strobe_o = 1'b0;
        sclk_o   = 1'b0;
        valid_o  = 1'b0;
        busy_o   = 1'b1;
        unique case (state_q)
            ST_IDLE:    busy_o   = 1'b0;
            ST_STROBE:  strobe_o = 1'b1;
            ST_CONVERT: ;
            ST_CLK_LO:  ;
            ST_CLK_HI:  sclk_o   = 1'b1;
            ST_DONE:    valid_o  = 1'b1;
            default:    busy_o   = 1'b0;
        endcase
    end

    assign result_o    = result_q;
    assign result_ch_o = res_ch_q;
    assign next_ch_o   = next_ch_q;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NBITS      = 12,
    parameter int STROBE_CYC = 120,
    parameter int HALF_CYC   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_o,
    input logic             sclk_o,
    input logic             busy_o,
    input logic             valid_o,
    input logic [NBITS-1:0] result_o,
    input logic             next_ch_o
);

    logic [31:0] strobe_len_q;
    logic [31:0] sclk_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_len_q <= '0;
            sclk_len_q   <= '0;
        end else begin
            strobe_len_q <= strobe_o ? strobe_len_q + 32'd1 : 32'd0;
            sclk_len_q   <= sclk_o ? sclk_len_q + 32'd1 : 32'd0;
        end
    end

    // R2
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_o) |-> (strobe_len_q == STROBE_CYC));

    // R2
    start_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $rose(strobe_o));

    // R4
    sclk_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> (sclk_len_q == HALF_CYC));

    // R4
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_o && sclk_o));

    // R4
    sclk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> busy_o);

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(result_o));

    // R7
    valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !busy_o);

    // R10
    chan_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !next_ch_o);

endmodule

bind sar_seq_ctrl sar_seq_chk #(
    .NBITS      (NBITS),
    .STROBE_CYC (PWRUP_CYC + TRACK_CYC),
    .HALF_CYC   (HALF_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_o  (strobe_o),
    .sclk_o    (sclk_o),
    .busy_o    (busy_o),
    .valid_o   (valid_o),
    .result_o  (result_o),
    .next_ch_o (next_ch_o)
);

// File: tb/sar_seq_ctrl_test.sv
module sar_seq_ctrl_test;

    localparam int NB  = 12;
    localparam int PWR = 2;
    localparam int TRK = 3;
    localparam int CNV = 7;
    localparam int HLF = 1;
    localparam int STB = PWR + TRK;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          ch2_req_i = 1'b0;
    logic          sdata_i = 1'b0;
    logic          strobe_o, sclk_o, busy_o, valid_o, result_ch_o, next_ch_o;
    logic [NB-1:0] result_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sar_seq_ctrl #(
        .NBITS(NB), .PWRUP_CYC(PWR), .TRACK_CYC(TRK), .CONV_CYC(CNV), .HALF_CYC(HLF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ch2_req_i(ch2_req_i),
        .sdata_i(sdata_i), .strobe_o(strobe_o), .sclk_o(sclk_o), .busy_o(busy_o),
        .valid_o(valid_o), .result_o(result_o), .result_ch_o(result_ch_o),
        .next_ch_o(next_ch_o)
    );

    // converter model: loads on falling strobe, shifts on falling sclk,
    // picks input 2 after a short readout
    logic [NB-1:0] code_a = '0;
    logic [NB-1:0] code_b = '0;
    logic [NB-1:0] out_word = '0;
    int            rd_bits = NB;
    bit            armed = 1'b0;
    bit            conv_sel = 1'b0;

    always @(posedge strobe_o) begin
        conv_sel = (rd_bits < NB);
        armed = 1'b1;
    end
    always @(negedge strobe_o) begin
        if (armed) begin
            out_word = conv_sel ? code_b : code_a;
            sdata_i = out_word[NB-1];
            rd_bits = 0;
        end
    end
    always @(posedge sclk_o) rd_bits++;
    always @(negedge sclk_o) begin
        out_word = out_word << 1;
        sdata_i = out_word[NB-1];
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run_conv(input logic [NB-1:0] c1, input logic [NB-1:0] c2,
                            input bit req2, input bit poke);
        int k = 0;
        int busy_n = 0, stb_n = 0, sclk_n = 0, rises = 0, stb_rises = 0;
        int t_stb = 0, t_clk = -1, valid_n = 0, res = 0, res_ch = 0, nch_at2 = 0;
        bit prev_sclk = 1'b0, prev_stb = 1'b0;
        int passes = req2 ? 2 : 1;
        logic [NB-1:0] exp_res;
        code_a = c1;
        code_b = c2;
        exp_res = req2 ? c2 : c1;
        @(negedge clk);
        start_i = 1'b1;
        ch2_req_i = req2;
        @(negedge clk);
        start_i = 1'b0;
        ch2_req_i = 1'b0;
        while (busy_o && k < 1000) begin
            busy_n++;
            if (strobe_o) begin
                stb_n++;
                t_stb = k;
                if (!prev_stb) begin
                    stb_rises++;
                    if (stb_rises == 2) nch_at2 = int'(next_ch_o);
                end
            end
            if (sclk_o) begin
                sclk_n++;
                if (!prev_sclk) rises++;
                if (t_clk < 0) t_clk = k;
            end
            if (valid_o) begin
                valid_n++;
                res = int'(result_o);
                res_ch = int'(result_ch_o);
                chk("R10 next_ch cleared at valid", int'(next_ch_o), 0);
            end
            prev_sclk = sclk_o;
            prev_stb = strobe_o;
            k++;
            start_i = (poke && (k == 3 || k == STB + 2)) ? 1'b1 : 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk("R2 strobe high cycles", stb_n, passes * STB);
        chk("R2 strobe edges", stb_rises, passes);
        chk("R3 strobe-to-sclk gap", t_clk - t_stb, CNV + HLF + 1);
        chk("R4 sclk pulses", rises, NB);
        chk("R4 sclk high cycles", sclk_n, NB * HLF);
        chk("R5 result word", res, int'(exp_res));
        chk("R6 valid pulses", valid_n, 1);
        chk("R7 busy cycles", busy_n, passes * (STB + CNV) + 2 * NB * HLF + 1);
        chk("R10 result channel", res_ch, int'(req2));
        if (req2) chk("R9 next_ch at second strobe", nch_at2, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            chk("R8 no strobe after ignored start", int'(strobe_o), 0);
            chk("R8 idle after ignored start", int'(busy_o), 0);
        end
        @(negedge clk);
        chk("R6 result held after valid", int'(result_o), int'(exp_res));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 strobe in reset", int'(strobe_o), 0);
        chk("R1 busy in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobe", int'(strobe_o), 0);
        chk("R1 sclk", int'(sclk_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 next_ch", int'(next_ch_o), 0);
        chk("R1 result", int'(result_o), 0);

        run_conv(12'h000, 12'hFFF, 1'b0, 1'b0);
        run_conv(12'hFFF, 12'h000, 1'b0, 1'b0);
        run_conv(12'hA5C, 12'h3C1, 1'b1, 1'b0);
        for (int b = 0; b < NB; b++) begin
            run_conv(NB'(1) << b, ~(NB'(1) << b), 1'b0, 1'b0);
            run_conv(NB'(1) << b, ~(NB'(1) << b), 1'b1, 1'b1);
        end
        for (int i = 0; i < 1024; i++) begin
            logic [NB-1:0] c;
            c = NB'(i * 4 + ((i >> 3) & 3));
            run_conv(c, c ^ 12'hA5A, (i % 8) == 5, (i % 16) == 9);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule